// File: doc/BRIEF.md
# Global Timer Clock Prescaler

This block turns the system clock into the count-enable pulses for a bank of timer channels. A global divider produces one enable tick every N+1 clocks, where N is an 8-bit ratio. Each channel then divides those ticks again by 1 to 4 through its own small divider. It emits a single-cycle pulse whenever its own count wraps, and the channel counter advances on that pulse. All settings are loaded through a simple write port with an address and a data word. Address 0 is the global control. Address k+1 is the configuration of channel k.

The global enable is the master switch. Clearing it halts every channel at once and returns every divide counter to zero. The next enable is therefore a common phase reference: channels configured while the block is disabled pulse in lockstep. A channel configured while the block runs keeps the same rate, but its phase is set by the moment of its own write. The debug freeze input and the external time-base enable input are accepted but do not gate this block. A ratio written while the block runs is held back until the current period ends.

Top module: `gtp_top`

## Requirements
- R1: A write to address 0 loads the global ratio from wr_data[7:0]. A value N produces one global tick every N+1 clocks: 0 gives a tick on every clock and 255 gives one every 256 clocks.
- R2: A write to address k+1 configures channel k. wr_data[1:0] holds the channel ratio C and wr_data[2] holds the channel enable. The channel pulses on every (C+1)-th global tick. Cycle 0 is the cycle right after the clock edge that takes the global enabling write. The first pulse of a channel configured before that write falls in cycle (N+1)(C+1)-1, and later pulses follow every (N+1)(C+1) clocks.
- R3: wr_data[8] at address 0 is the global enable. While it is clear, no channel pulses.
- R4: The dbg_freeze input does not change the pulse timing.
- R5: Driving ext_tbase_en low does not stop or change the pulse timing.
- R6: Clearing the global enable returns the global and all channel divide counters to zero. A later enable therefore gives the same first-pulse timing as the first enable after reset.
- R7: A ratio written to address 0 while the block is enabled leaves the current period unchanged. The new ratio applies from the period that follows, so no shortened period occurs.
- R8: Channels with equal ratios that are configured before the global enable is set pulse in the same clock cycles.
- R9: A write to a channel restarts that channel's divide count. If a channel is written while the block runs, its pulses are offset from those of other channels by the time of its own write.
- R10: A channel whose enable bit is 0 produces no pulses, while the other channels continue.
- R11: After reset, the global enable and all channel enables are clear and no pulses are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_addr | input | ADDR_W (3) | 0 = global control; k+1 = channel k |
| wr_data | input | GRATIO_W+1 (9) | Write data; field layout per R1, R2, R3 |
| dbg_freeze | input | 1 | Debug freeze indication; ignored by this block |
| ext_tbase_en | input | 1 | External time-base enable; ignored by this block |
| ch_cnt_en | output | NUM_CH (4) | Per-channel single-cycle count-enable pulses |

## Verification
The division path is driven with a table of global and channel ratio pairs chosen so that their products repeat while the factors differ: 1, 4, 6, 8 (reached two ways) and 15. These pairs separate a wrong global modulus from a wrong channel modulus, and they separate an off-by-one in the first pulse from one in the period. Directed patterns cover the extremes of the ratio field and a ratio rewrite in the middle of a period. That rewrite tells a deferred load apart from an immediate one, and the cycle-exact pulse map exposes a missing or extra pulse. Further patterns disable the block part-way through a channel's count and check that the restart timing matches a fresh start. Two channels are compared cycle by cycle, once configured before the enable and once with one configured during the run, which shows lockstep against a write-relative offset. The freeze and time-base inputs are held at their "stop" values during an ordinary timing run.

// File: rtl/gtp_pkg.sv
package gtp_pkg;

  // Width of a channel ratio field; divide range is 1 .. 2**CH_RATIO_W
  localparam int unsigned CH_RATIO_W = 2;
  // Position of the channel enable bit in a channel write
  localparam int unsigned CH_EN_BIT  = CH_RATIO_W;

  typedef struct packed {
    logic                  en;
    logic [CH_RATIO_W-1:0] ratio;
  } ch_cfg_t;

  // Split a raw channel write word into its fields
  function automatic ch_cfg_t ch_cfg_from_word(input logic [CH_RATIO_W:0] raw);
    ch_cfg_t c;
    c.en    = raw[CH_EN_BIT];
    c.ratio = raw[CH_RATIO_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/gtp_wr_decode.sv
module gtp_wr_decode #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              glb_wr,
  output logic [NUM_CH-1:0] ch_wr
);

  assign glb_wr = wr_en && (wr_addr == '0);

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch_sel
    assign ch_wr[k] = wr_en && (wr_addr == ADDR_W'(k + 1));
  end

  // R2: each write reaches at most one register target
  p_single_target_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ch_wr, glb_wr}));

endmodule

// File: rtl/gtp_global_div.sv
module gtp_global_div #(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               cfg_en,
  input  logic               dbg_freeze,
  input  logic               tb_en,
  output logic               run,
  output logic               tick
);

  logic [RATIO_W-1:0] pend_ratio;   // last written ratio
  logic [RATIO_W-1:0] live_ratio;   // ratio of the period in progress
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] next_pend;
  logic               next_run;
  logic               period_end;
  logic               cnt_clear;

  function automatic logic at_terminal(input logic [RATIO_W-1:0] c,
                                       input logic [RATIO_W-1:0] lim);
    return c == lim;
  endfunction

  function automatic logic [RATIO_W-1:0] step(input logic [RATIO_W-1:0] c,
                                              input logic             clr);
    return clr ? '0 : c + 1'b1;
  endfunction

  assign next_pend  = cfg_wr ? cfg_ratio : pend_ratio;
  assign next_run   = cfg_wr ? cfg_en    : run;
  assign period_end = run && at_terminal(cnt, live_ratio);
  assign cnt_clear  = !run || !next_run || period_end;
  assign tick       = period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run        <= 1'b0;
      pend_ratio <= '0;
      live_ratio <= '0;
      cnt        <= '0;
    end else begin
      run        <= next_run;
      pend_ratio <= next_pend;
      if (!run || period_end)
        live_ratio <= next_pend;
      cnt        <= step(cnt, cnt_clear);
    end
  end

  // R1: count never passes the active terminal value
  p_cnt_bounded_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= live_ratio);

  // R6: a disabled divider holds its count at zero
  p_clear_when_off_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R7: the active ratio only changes at a period boundary
  p_live_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    run && !period_end |=> $stable(live_ratio));

  // R4: freeze does not hold the count
  p_freeze_ignored_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    dbg_freeze && run && !period_end && !cfg_wr |=> cnt == $past(cnt) + 1'b1);

  // R5: a low time-base enable does not hold the count
  p_tbase_ignored_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en && run && !period_end && !cfg_wr |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/gtp_chan_div.sv
module gtp_chan_div
  import gtp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    glb_run,
  input  logic    glb_tick,
  input  logic    cfg_wr,
  input  ch_cfg_t cfg,
  output logic    cnt_en
);

  ch_cfg_t               cur;
  logic [CH_RATIO_W-1:0] ccnt;
  logic                  wrap;

  function automatic logic [CH_RATIO_W-1:0] advance(input logic [CH_RATIO_W-1:0] c,
                                                    input logic                  w);
    return w ? '0 : c + 1'b1;
  endfunction

  assign wrap   = (ccnt == cur.ratio);
  assign cnt_en = glb_tick && cur.en && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur  <= '0;
      ccnt <= '0;
    end else if (cfg_wr) begin
      cur  <= cfg;
      ccnt <= '0;
    end else if (!glb_run || !cur.en) begin
      ccnt <= '0;
    end else if (glb_tick) begin
      ccnt <= advance(ccnt, wrap);
    end
  end

  // R2: the channel count stays within its ratio
  p_chan_bounded_r2 : assert property (@(posedge clk) disable iff (!rst_n)
    cur.en |-> ccnt <= cur.ratio);

  // R6: global disable zeroes the channel count
  p_chan_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !glb_run |=> ccnt == '0);

  // R10: a disabled channel keeps its count at zero
  p_chan_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    !cur.en |=> ccnt == '0);

  // R9: a channel write restarts the channel count
  p_chan_restart_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ccnt == '0);

endmodule

// File: rtl/gtp_top.sv
module gtp_top
  import gtp_pkg::*;
#(
  parameter  int NUM_CH   = 4,
  parameter  int GRATIO_W = 8,
  localparam int ADDR_W   = $clog2(NUM_CH + 1),
  localparam int DATA_W   = GRATIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_freeze,
  input  logic              ext_tbase_en,
  output logic [NUM_CH-1:0] ch_cnt_en
);

  logic              glb_wr;
  logic [NUM_CH-1:0] ch_wr;
  logic              glb_run;
  logic              glb_tick;
  ch_cfg_t           ch_word;

  assign ch_word = ch_cfg_from_word(wr_data[CH_RATIO_W:0]);

  gtp_wr_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .glb_wr  (glb_wr),
    .ch_wr   (ch_wr)
  );

  gtp_global_div #(
    .RATIO_W (GRATIO_W)
  ) u_gdiv (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (glb_wr),
    .cfg_ratio  (wr_data[GRATIO_W-1:0]),
    .cfg_en     (wr_data[GRATIO_W]),
    .dbg_freeze (dbg_freeze),
    .tb_en      (ext_tbase_en),
    .run        (glb_run),
    .tick       (glb_tick)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    gtp_chan_div u_cdiv (
      .clk      (clk),
      .rst_n    (rst_n),
      .glb_run  (glb_run),
      .glb_tick (glb_tick),
      .cfg_wr   (ch_wr[k]),
      .cfg      (ch_word),
      .cnt_en   (ch_cnt_en[k])
    );
  end

  // R3: no channel pulse while the global enable is clear
  p_pulse_gated_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    !glb_run |-> ch_cnt_en == '0);

  // R1: every channel pulse coincides with a global tick
  p_pulse_on_tick_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    (ch_cnt_en != '0) |-> glb_tick);

  // R11: the first cycle after reset release is quiet
  p_reset_quiet_r11 : assert property (@(posedge clk)
    !rst_n |=> ch_cnt_en == '0);

endmodule

// File: tb/sim_gtp_top.sv
module sim_gtp_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [8:0] wr_data = '0;
  logic       dbg_freeze = 1'b0;
  logic       ext_tbase_en = 1'b1;
  logic [3:0] ch_cnt_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  gtp_top u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .dbg_freeze   (dbg_freeze),
    .ext_tbase_en (ext_tbase_en),
    .ch_cnt_en    (ch_cnt_en)
  );

  // {global ratio, channel ratio}
  localparam int NVEC = 6;
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd0, 2'd0}, {8'd0, 2'd3}, {8'd2, 2'd1},
    {8'd7, 2'd0}, {8'd4, 2'd2}, {8'd1, 2'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [8:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [8:0] glb_word(input bit en, input int n);
    return {en, 8'(n)};
  endfunction

  function automatic logic [8:0] ch_word(input bit en, input int c);
    return {6'd0, en, 2'(c)};
  endfunction

  // samples channel ch for w cycles, starting at the current sample point
  task automatic window(input int ch, input int w, output int first, output int count);
    first = -1; count = 0;
    for (int i = 0; i < w; i++) begin
      if (ch_cnt_en[ch]) begin
        if (first < 0) first = i;
        count++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f, c, f1, c1, p, coinc, mism;
    logic [19:0] mask, exp_mask;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: quiet after reset
    c = 0;
    for (int i = 0; i < 5; i++) begin
      if (ch_cnt_en != 0) c++;
      @(negedge clk);
    end
    check(c == 0, "R11 reset idle", c, 0);

    // R3: channels enabled, global off
    for (int k = 0; k < 4; k++) wr(3'(k + 1), ch_word(1, 0));
    c = 0;
    for (int i = 0; i < 20; i++) begin
      if (ch_cnt_en != 0) c++;
      @(negedge clk);
    end
    check(c == 0, "R3 global off", c, 0);

    // R1/R2: ratio table
    for (int v = 0; v < NVEC; v++) begin
      int gn, cn;
      gn = int'(VEC[v][9:2]);
      cn = int'(VEC[v][1:0]);
      p  = (gn + 1) * (cn + 1);
      wr(3'd1, ch_word(1, cn));
      wr(3'd0, glb_word(1, gn));
      window(0, 64, f, c);
      check(f == p - 1, "R2 first pulse", f, p - 1);
      check(c == 64 / p, "R1 pulse count", c, 64 / p);
      wr(3'd0, glb_word(0, gn));
    end

    // R1 boundary: ratio 255
    wr(3'd1, ch_word(1, 0));
    wr(3'd0, glb_word(1, 255));
    window(0, 300, f, c);
    check(f == 255, "R1 max ratio first", f, 255);
    check(c == 1, "R1 max ratio count", c, 1);
    wr(3'd0, glb_word(0, 0));

    // R8: lockstep of channels set before enable
    wr(3'd1, ch_word(1, 1));
    wr(3'd2, ch_word(1, 1));
    wr(3'd0, glb_word(1, 2));
    mism = 0; c = 0;
    for (int i = 0; i < 48; i++) begin
      if (ch_cnt_en[0] != ch_cnt_en[1]) mism++;
      if (ch_cnt_en[0]) c++;
      @(negedge clk);
    end
    check(mism == 0, "R8 lockstep mismatches", mism, 0);
    check(c == 8, "R8 pulse count", c, 8);
    wr(3'd0, glb_word(0, 2));

    // R9: channel written while running gets its own phase
    wr(3'd1, ch_word(1, 1));
    wr(3'd0, glb_word(1, 0));
    @(negedge clk);
    wr(3'd2, ch_word(1, 1));
    coinc = 0; c = 0; c1 = 0;
    for (int i = 0; i < 20; i++) begin
      if (ch_cnt_en[0] && ch_cnt_en[1]) coinc++;
      if (ch_cnt_en[0]) c++;
      if (ch_cnt_en[1]) c1++;
      @(negedge clk);
    end
    check(coinc == 0, "R9 coincident pulses", coinc, 0);
    check(c1 == 10, "R9 late channel count", c1, 10);
    check(c == 10, "R9 early channel count", c, 10);
    wr(3'd0, glb_word(0, 0));

    // R10: disabled channel stays silent
    wr(3'd1, ch_word(1, 0));
    wr(3'd3, ch_word(0, 0));
    wr(3'd0, glb_word(1, 0));
    c = 0; c1 = 0;
    for (int i = 0; i < 20; i++) begin
      if (ch_cnt_en[2]) c1++;
      if (ch_cnt_en[0]) c++;
      @(negedge clk);
    end
    check(c1 == 0, "R10 disabled channel", c1, 0);
    check(c == 20, "R10 enabled neighbour", c, 20);
    wr(3'd0, glb_word(0, 0));

    // R7: ratio rewrite mid-period
    wr(3'd1, ch_word(1, 0));
    wr(3'd0, glb_word(1, 3));
    mask = '0;
    for (int i = 0; i < 20; i++) begin
      mask[i] = ch_cnt_en[0];
      if (i == 5) begin
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = glb_word(1, 1);
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    exp_mask = '0;
    exp_mask[3] = 1'b1;
    exp_mask[7] = 1'b1;
    for (int j = 9; j < 20; j += 2) exp_mask[j] = 1'b1;
    check(mask == exp_mask, "R7 pulse map", int'(mask), int'(exp_mask));
    wr(3'd0, glb_word(0, 1));

    // R6: disable mid-count clears global and channel phase
    wr(3'd1, ch_word(1, 1));
    wr(3'd0, glb_word(1, 2));
    repeat (9) @(negedge clk);
    wr(3'd0, glb_word(0, 2));
    repeat (3) @(negedge clk);
    wr(3'd0, glb_word(1, 2));
    window(0, 12, f, c);
    check(f == 5, "R6 restart first pulse", f, 5);
    check(c == 2, "R6 restart count", c, 2);
    wr(3'd0, glb_word(0, 2));

    // R4/R5: freeze asserted and time-base enable low
    dbg_freeze = 1'b1;
    ext_tbase_en = 1'b0;
    wr(3'd1, ch_word(1, 0));
    wr(3'd0, glb_word(1, 1));
    window(0, 32, f, c);
    check(f == 1, "R4 R5 first pulse", f, 1);
    check(c == 16, "R4 R5 pulse count", c, 16);
    wr(3'd0, glb_word(0, 1));
    dbg_freeze = 1'b0;
    ext_tbase_en = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule